// File: doc/BRIEF.md
# Card Clock Divider with Gating

This block derives the clock that drives a memory or I/O card from a faster reference clock. Software sets three values through single-cycle write strobes on the bus-side clock: an even divider value, a run bit and a low-power bit. These values sit in bus-side registers and have no effect yet. They reach the reference domain only when an update-only command is written. While that command is in flight, the block holds a busy flag high. The flag drops once the new setting drives the output. Software polls the flag for zero before it writes the next command.

The output period is 2·n reference cycles, and n = 0 routes the reference straight through. A new ratio, a stop or a start takes effect only when the output is low, so no pulse is ever shortened. In low-power mode, an idle input from the command/data engine stops the clock. The clock starts counting again on the first reference edge at which idle is low.

The block has no streaming interface. Writes are fire-and-forget strobes with no back-pressure, and a command that arrives while busy is dropped.

Top module: `card_clk_gen`

## Requirements
- R1: After reset, card_clk is low and stays without edges, busy is low, and the active setting is n = 0 with the clock disabled.
- R2: With a divider value n from 1 to 255 applied and the clock enabled, card_clk has a period of exactly 2·n reference cycles and a 50 % duty cycle.
- R3: With n = 0 applied and the clock enabled, card_clk follows ref_clk and has a period of one reference cycle.
- R4: Divider writes (wr_data[7:0]) and run/low-power writes (wr_data[0] run, wr_data[16] low-power) do not change card_clk until an update-only command is accepted.
- R5: A command write with wr_data[31] (start) and wr_data[21] (update-only) both set, taken while busy is low, raises busy on the next bus clock. busy falls only after the captured setting drives card_clk.
- R6: A command write with the start bit set and the update-only bit clear is ignored: busy stays low and card_clk is unchanged.
- R7: An update-only command written while busy is high is ignored. The setting captured by the first command is the one applied, and busy does not rise again.
- R8: With the run bit applied as 0, card_clk stays low after its current high phase.
- R9: With the low-power bit applied, card_clk stops low while card_idle is high and runs again when card_idle is low. With the low-power bit clear, card_idle has no effect.
- R10: Every high phase of the divided clock lasts exactly the n that was in force when it began. Ratio changes, stops and starts take effect only while the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side register clock |
| ref_clk | input | 1 | Reference clock that feeds the divider |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_div | input | 1 | Write strobe for the divider register |
| wr_ena | input | 1 | Write strobe for the run/low-power register |
| wr_cmd | input | 1 | Write strobe for the command register |
| wr_data | input | 32 | Write data shared by all three strobes |
| card_idle | input | 1 | Card idle indication, synchronous to ref_clk |
| card_clk | output | 1 | Divided, gated card clock |
| busy | output | 1 | Start flag: high while an update is pending |

## Verification
On every clock cycle, the assertions check the exact length of each divided high phase against the ratio in force when it began. They also check that the output stays low once it is stopped by the run bit or by idle in low-power mode, and that the busy flag follows accepted and ignored commands. Other behaviour shows up only at the ports over many cycles, so the bench scenarios cover it. This includes the measured periods across a sweep of ratios, pass-through, the deferral of settings until an update command, and the dropping of a command issued while busy.

// File: rtl/ccg_pkg.sv
`timescale 1ns/1ps
package ccg_pkg;
  // command word decode
  localparam int CMD_START_BIT = 31;
  localparam int CMD_UPD_BIT   = 21;
  // run/low-power word decode
  localparam int ENA_RUN_BIT   = 0;
  localparam int ENA_LP_BIT    = 16;
endpackage

// File: rtl/ccg_sync.sv
`timescale 1ns/1ps
module ccg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/ccg_bus_regs.sv
`timescale 1ns/1ps
module ccg_bus_regs
  import ccg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             bus_clk,
  input  logic             rst_n,
  input  logic             wr_div,
  input  logic             wr_ena,
  input  logic             wr_cmd,
  input  logic [31:0]      wr_data,
  input  logic             ack_s,
  output logic [DIV_W-1:0] snap_div,
  output logic             snap_en,
  output logic             snap_lp,
  output logic             req_tgl,
  output logic             busy
);
  logic [DIV_W-1:0] div_r;
  logic             en_r;
  logic             lp_r;
  logic             upd_go;
  logic             unused_data;

  assign unused_data = ^wr_data;
  assign upd_go = wr_cmd && wr_data[CMD_START_BIT] && wr_data[CMD_UPD_BIT] && !busy;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      div_r    <= '0;
      en_r     <= 1'b0;
      lp_r     <= 1'b0;
      snap_div <= '0;
      snap_en  <= 1'b0;
      snap_lp  <= 1'b0;
      req_tgl  <= 1'b0;
      busy     <= 1'b0;
    end else begin
      if (wr_div) div_r <= wr_data[DIV_W-1:0];
      if (wr_ena) begin
        en_r <= wr_data[ENA_RUN_BIT];
        lp_r <= wr_data[ENA_LP_BIT];
      end
      if (upd_go) begin
        // snapshot stays frozen until the card side acknowledges
        snap_div <= div_r;
        snap_en  <= en_r;
        snap_lp  <= lp_r;
        req_tgl  <= ~req_tgl;
        busy     <= 1'b1;
      end else if (busy && (ack_s == req_tgl)) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ccg_divider.sv
`timescale 1ns/1ps
module ccg_divider #(
  parameter int DIV_W = 8
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             req_s,
  input  logic [DIV_W-1:0] new_div,
  input  logic             new_en,
  input  logic             new_lp,
  input  logic             card_idle,
  output logic             ack_tgl,
  output logic             div_q,
  output logic             pass_en,
  output logic [DIV_W-1:0] act_div,
  output logic             act_en,
  output logic             act_lp
);
  logic [DIV_W-1:0] cnt;
  logic thru, run, term, pend, bnd;

  always_comb begin
    thru = (act_div == '0);
    run  = act_en && !(act_lp && card_idle);
    term = (cnt == act_div - DIV_W'(1));
    pend = (req_s != ack_tgl);
    // a low-phase boundary: a falling edge now, or output parked low
    bnd  = (div_q && term) || (!div_q && (thru || !run));
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div <= '0;
      act_en  <= 1'b0;
      act_lp  <= 1'b0;
      ack_tgl <= 1'b0;
      div_q   <= 1'b0;
      cnt     <= '0;
    end else if (pend && bnd) begin
      act_div <= new_div;
      act_en  <= new_en;
      act_lp  <= new_lp;
      ack_tgl <= ~ack_tgl;
      div_q   <= 1'b0;
      cnt     <= '0;
    end else if (thru || (!div_q && !run)) begin
      div_q <= 1'b0;
      cnt   <= '0;
    end else if (term) begin
      div_q <= ~div_q;
      cnt   <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  // pass-through gate changes only while ref_clk is low
  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) pass_en <= 1'b0;
    else        pass_en <= thru && run;
  end
endmodule

// File: rtl/card_clk_gen.sv
`timescale 1ns/1ps
module card_clk_gen #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        bus_clk,
  input  logic        ref_clk,
  input  logic        rst_n,
  input  logic        wr_div,
  input  logic        wr_ena,
  input  logic        wr_cmd,
  input  logic [31:0] wr_data,
  input  logic        card_idle,
  output logic        card_clk,
  output logic        busy
);
  logic [DIV_W-1:0] snap_div;
  logic             snap_en, snap_lp;
  logic             req_tgl, req_s;
  logic             ack_tgl, ack_s;
  logic             div_q, pass_en;
  logic [DIV_W-1:0] act_div;
  logic             act_en, act_lp;

  ccg_bus_regs #(.DIV_W(DIV_W)) u_regs (
    .bus_clk (bus_clk),
    .rst_n   (rst_n),
    .wr_div  (wr_div),
    .wr_ena  (wr_ena),
    .wr_cmd  (wr_cmd),
    .wr_data (wr_data),
    .ack_s   (ack_s),
    .snap_div(snap_div),
    .snap_en (snap_en),
    .snap_lp (snap_lp),
    .req_tgl (req_tgl),
    .busy    (busy)
  );

  ccg_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
  );

  ccg_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(bus_clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s)
  );

  ccg_divider #(.DIV_W(DIV_W)) u_div (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .req_s    (req_s),
    .new_div  (snap_div),
    .new_en   (snap_en),
    .new_lp   (snap_lp),
    .card_idle(card_idle),
    .ack_tgl  (ack_tgl),
    .div_q    (div_q),
    .pass_en  (pass_en),
    .act_div  (act_div),
    .act_en   (act_en),
    .act_lp   (act_lp)
  );

  assign card_clk = div_q | (ref_clk & pass_en);
endmodule

// File: rtl/ccg_checker.sv
`timescale 1ns/1ps
module ccg_checker
  import ccg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input logic             bus_clk,
  input logic             ref_clk,
  input logic             rst_n,
  input logic             wr_cmd,
  input logic [31:0]      wr_data,
  input logic             busy,
  input logic             div_q,
  input logic [DIV_W-1:0] act_div,
  input logic             act_en,
  input logic             act_lp,
  input logic             card_idle
);
  logic [DIV_W:0]   hi_cnt;
  logic [DIV_W-1:0] n_rise;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= (DIV_W+1)'(1);
      n_rise <= '0;
    end else if (!div_q) begin
      hi_cnt <= (DIV_W+1)'(1);
      n_rise <= act_div;
    end else begin
      hi_cnt <= hi_cnt + (DIV_W+1)'(1);
    end
  end

  AST_UPD_SETS_BUSY: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_cmd && wr_data[CMD_START_BIT] && wr_data[CMD_UPD_BIT] && !busy) |=> busy); // R5

  AST_PLAIN_CMD_IGNORED: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_cmd && !wr_data[CMD_UPD_BIT] && !busy) |=> !busy); // R6

  AST_HIGH_ENDS_ON_TIME: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (div_q && (hi_cnt == {1'b0, n_rise})) |=> !div_q); // R10

  AST_HIGH_NOT_SHORT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (div_q && (hi_cnt < {1'b0, n_rise})) |=> div_q); // R10

  AST_OFF_STAYS_LOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!act_en && !div_q) |=> !div_q); // R8

  AST_IDLE_STAYS_LOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (act_lp && card_idle && !div_q) |=> !div_q); // R9
endmodule

bind card_clk_gen ccg_checker #(.DIV_W(DIV_W)) u_chk (
  .bus_clk  (bus_clk),
  .ref_clk  (ref_clk),
  .rst_n    (rst_n),
  .wr_cmd   (wr_cmd),
  .wr_data  (wr_data),
  .busy     (busy),
  .div_q    (div_q),
  .act_div  (act_div),
  .act_en   (act_en),
  .act_lp   (act_lp),
  .card_idle(card_idle)
);

// File: tb/tb_card_clk_gen.sv
`timescale 1ns/1ps
module tb_card_clk_gen;
  localparam longint TREF = 10;

  logic        bus_clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_div = 1'b0, wr_ena = 1'b0, wr_cmd = 1'b0;
  logic [31:0] wr_data = '0;
  logic        card_idle = 1'b0;
  logic        card_clk, busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  card_clk_gen dut (
    .bus_clk(bus_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .wr_div(wr_div), .wr_ena(wr_ena), .wr_cmd(wr_cmd), .wr_data(wr_data),
    .card_idle(card_idle), .card_clk(card_clk), .busy(busy)
  );

  always #2 bus_clk = ~bus_clk;
  initial begin
    #1;
    forever #5 ref_clk = ~ref_clk;
  end

  int unsigned edges = 0;
  longint t_last = 0, t_prev = 0;
  always @(posedge card_clk) begin
    t_prev = t_last;
    t_last = $time;
    edges++;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int sel, input logic [31:0] d);
    @(negedge bus_clk);
    wr_data = d;
    wr_div  = (sel == 0);
    wr_ena  = (sel == 1);
    wr_cmd  = (sel == 2);
    @(negedge bus_clk);
    wr_div = 1'b0; wr_ena = 1'b0; wr_cmd = 1'b0;
  endtask

  task automatic wait_free(input string req);
    int k = 0;
    while (busy && k < 5000) begin
      @(negedge bus_clk);
      k++;
    end
    chk(req, busy, 0);
  endtask

  // R4/R5: stage values, then the update-only command
  task automatic apply(input int n, input bit en, input bit lp);
    bus_wr(0, 32'(n));
    bus_wr(1, (32'(lp) << 16) | 32'(en));
    bus_wr(2, 32'h8020_0000);
    chk("R5 busy after update", busy, 1);
    wait_free("R5 busy clears");
  endtask

  task automatic meas(input int n, output longint per, output longint cnt);
    int unsigned e0;
    int m = (n == 0) ? 1 : n;
    repeat (2 * m + 4) @(posedge ref_clk);
    e0 = edges;
    repeat (8 * m + 10) @(posedge ref_clk);
    cnt = longint'(edges - e0);
    per = t_last - t_prev;
  endtask

  function automatic longint exp_per(input int n);
    return (n == 0) ? TREF : 2 * TREF * n;
  endfunction

  initial begin
    longint per, cnt;
    #37 rst_n = 1'b1;

    // R1: reset state
    meas(4, per, cnt);
    chk("R1 no edges after reset", cnt, 0);
    @(negedge bus_clk);
    chk("R1 card_clk low", card_clk, 0);
    chk("R1 busy low", busy, 0);

    // R2/R3 sweep
    for (int n = 0; n <= 16; n++) begin
      int nv = (n == 16) ? 255 : n;
      apply(nv, 1'b1, 1'b0);
      meas(nv, per, cnt);
      chk((nv == 0) ? "R3 pass-through period" : "R2 divided period", per, exp_per(nv));
      chk("R10 edges present", (cnt > 1) ? 1 : 0, 1);
    end

    // R4: staged writes do nothing without the command
    apply(3, 1'b1, 1'b0);
    bus_wr(0, 32'd7);
    bus_wr(1, 32'd0);
    meas(7, per, cnt);
    chk("R4 period held", per, exp_per(3));
    chk("R4 still running", (cnt > 1) ? 1 : 0, 1);

    // R6: start without update-only ignored
    bus_wr(0, 32'd5);
    bus_wr(1, 32'd1);
    bus_wr(2, 32'h8000_0000);
    chk("R6 busy stays low", busy, 0);
    meas(5, per, cnt);
    chk("R6 period held", per, exp_per(3));

    // R7: second command while busy dropped
    bus_wr(2, 32'h8020_0000);
    bus_wr(0, 32'd9);
    bus_wr(2, 32'h8020_0000);
    wait_free("R7 busy clears");
    repeat (20) @(negedge bus_clk);
    chk("R7 busy not re-raised", busy, 0);
    meas(9, per, cnt);
    chk("R7 first snapshot applied", per, exp_per(5));

    // R8: run bit off
    apply(2, 1'b0, 1'b0);
    meas(2, per, cnt);
    chk("R8 no edges when off", cnt, 0);
    @(negedge ref_clk);
    chk("R8 card_clk low", card_clk, 0);

    // R9: low-power with idle
    apply(2, 1'b1, 1'b1);
    @(negedge ref_clk) card_idle = 1'b1;
    meas(2, per, cnt);
    chk("R9 stopped while idle", cnt, 0);
    @(negedge ref_clk) card_idle = 1'b0;
    meas(2, per, cnt);
    chk("R9 resumes period", per, exp_per(2));
    apply(0, 1'b1, 1'b1);
    @(negedge ref_clk) card_idle = 1'b1;
    meas(0, per, cnt);
    chk("R9 pass-through stopped", cnt, 0);
    apply(2, 1'b1, 1'b0);
    meas(2, per, cnt);
    chk("R9 idle ignored without low-power", per, exp_per(2));
    chk("R9 edges without low-power", (cnt > 1) ? 1 : 0, 1);
    @(negedge ref_clk) card_idle = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge bus_clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule